// File: doc/BRIEF.md
# Interrupt Source Pending/Queued State Controller

This block keeps the two-bit event state of one interrupt source. The state is a pending bit P, set when a notification has gone downstream and not yet been acknowledged, and a queued bit Q, which records events that arrive while P is set. Software controls the source through memory-mapped accesses to two pages, an end-of-interrupt page and a trigger page. The page, the offset and the direction of the access select the operation. Store data is never looked at, so the request port carries none.

Special loads on the end-of-interrupt page return the state held before the access and force a new one. These loads implement unmask, mask and end-of-interrupt. A store at one fixed offset is the store-form end-of-interrupt: it clears P, and if an event was queued it sends that event on at once. In the message variant any store to the trigger page fires the source. In the level variant (parameter `IS_LEVEL`) there is no trigger page. A rising edge of the input line fires the source, and any end-of-interrupt that leaves the line still high fires it again.

Notifications leave through a valid/ready port that carries the source number fixed by a parameter. Owed notifications are counted, so none is lost while the receiver is stalled.

Top module: `esb_src`

## Requirements
- R1: After reset the state is P=0 Q=0, `notifValid` is low and `rspValid` is low.
- R2: In the message variant, a store to any offset of the trigger page with state 00 queues one notification and moves the state to 10 (P is bit 1, Q is bit 0).
- R3: A trigger with state 10 or 11 gives state 11 and queues no notification. A trigger with state 01 (masked) leaves the state at 01 and queues nothing.
- R4: A load at end-of-interrupt page offset 0xC00 sets the state to 00. Every load is answered on `rspValid` exactly one cycle later, with the state held before the load in `rspData` bits [1:0] and zeros above.
- R5: A load at end-of-interrupt page offset 0xD00 sets the state to 01 and returns the old state.
- R6: A load at end-of-interrupt page offset 0x000 sets the state to 00 and returns the old state.
- R7: A store at end-of-interrupt page offset 0x400 gives state 10 and queues one notification when Q was 1. When Q was 0 it gives state 00.
- R8: Loads at any other offset, and loads on the trigger page, return the old state and change nothing. Stores to the end-of-interrupt page at offsets other than 0x400 change nothing and produce no response.
- R9: `notifValid` stays high, with `notifId` equal to `SRC_ID`, until it is taken with `notifReady`. Each queued notification is delivered once, in order.
- R10: In the level variant, a rising edge on `lvlIn` is a trigger, and stores to the trigger page are ignored.
- R11: In the level variant, an end-of-interrupt (load at 0x000 or 0xC00, store at 0x400) that is made while `lvlIn` is high is followed in the same cycle by a trigger.
- R12: When a request and a line trigger fall in the same cycle, the request's operation is applied first and the trigger acts on its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqPage | input | 1 | 0 = end-of-interrupt page, 1 = trigger page |
| reqOffset | input | OFF_W | Byte offset within the page |
| lvlIn | input | 1 | Level interrupt line (used by the level variant only) |
| rspValid | output | 1 | Load response valid, one cycle after the load |
| rspData | output | RD_W | Old state in bits [1:0] (P bit 1, Q bit 0), zero above |
| notifValid | output | 1 | Notification offered downstream |
| notifReady | input | 1 | Downstream accepts the notification |
| notifId | output | SRC_ID_W | Source number carried by the notification |

## Verification
The case that matters is a line edge, or a high line after an end-of-interrupt, arriving in the same cycle as a software access on the level variant. The bench sets each of the four starting states and raises the line in the very cycle it issues each of the eight kinds of access. It then compares the returned old state, the number of notifications drained and the final state read back against an arithmetic model that applies the access first and the trigger second. On the message variant a notification can be owed while an earlier one is still waiting. A receiver held not ready through several triggers checks that the backlog drains in full.

// File: rtl/esb_pkg.sv
package esb_pkg;

  // Page offsets that select an operation (bits above 11 must be zero)
  localparam logic [11:0] OFF_LD_EOI   = 12'h000;
  localparam logic [11:0] OFF_ST_EOI   = 12'h400;
  localparam logic [11:0] OFF_UNMASK   = 12'hC00;
  localparam logic [11:0] OFF_MASK     = 12'hD00;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SET00,
    OP_SET01,
    OP_QUERY,
    OP_STEOI,
    OP_TRIG
  } esbOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    esbOp_e op;
    logic   isLoad;
    logic   fire;
  } esbStrobe_t;

  // Trigger applied to a state: {notify, newState}
  function automatic logic [2:0] pqTrigger(input logic [1:0] pq);
    case (pq)
      2'b00:   return {1'b1, 2'b10};
      2'b01:   return {1'b0, 2'b01};
      default: return {1'b0, 2'b11};
    endcase
  endfunction

endpackage

// File: rtl/esb_ctrl.sv
module esb_ctrl
  import esb_pkg::*;
#(
  parameter int OFF_W    = 12,
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             reqPage,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic             lvlIn,
  output esbStrobe_t       strb
);

  localparam logic [OFF_W-1:0] LD_EOI = OFF_W'(OFF_LD_EOI);
  localparam logic [OFF_W-1:0] ST_EOI = OFF_W'(OFF_ST_EOI);
  localparam logic [OFF_W-1:0] UNMSK  = OFF_W'(OFF_UNMASK);
  localparam logic [OFF_W-1:0] MSK    = OFF_W'(OFF_MASK);

  logic   lvlQ;
  logic   lineEdge;
  logic   isEoi;
  esbOp_e opSel;

  always_ff @(posedge clk) begin
    if (!rstN) lvlQ <= 1'b0;
    else       lvlQ <= lvlIn;
  end

  assign lineEdge = lvlIn & ~lvlQ;

  // Address and direction decode
  always_comb begin
    opSel = OP_NONE;
    if (reqValid) begin
      if (!reqPage) begin
        if (!reqWrite) begin
          if (reqOffset == LD_EOI || reqOffset == UNMSK) opSel = OP_SET00;
          else if (reqOffset == MSK)                     opSel = OP_SET01;
          else                                           opSel = OP_QUERY;
        end else if (reqOffset == ST_EOI) begin
          opSel = OP_STEOI;
        end
      end else begin
        if (!reqWrite) opSel = OP_QUERY;
        else           opSel = IS_LEVEL ? OP_NONE : OP_TRIG;
      end
    end
  end

  assign isEoi = (opSel == OP_SET00) || (opSel == OP_STEOI);

  always_comb begin
    strb.op     = opSel;
    strb.isLoad = reqValid & ~reqWrite;
    strb.fire   = IS_LEVEL & (lineEdge | (isEoi & lvlIn));
  end

endmodule

// File: rtl/esb_dp.sv
module esb_dp
  import esb_pkg::*;
#(
  parameter int              RD_W     = 8,
  parameter int              NOTE_W   = 3,
  parameter int              SRC_ID_W = 8,
  parameter logic [SRC_ID_W-1:0] SRC_ID = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  esbStrobe_t          strb,
  input  logic                notifReady,
  output logic                rspValid,
  output logic [RD_W-1:0]     rspData,
  output logic                notifValid,
  output logic [SRC_ID_W-1:0] notifId,
  output logic [1:0]          pqNow
);

  localparam logic [NOTE_W-1:0] CNT_MAX = '1;

  logic [1:0]        pqQ;
  logic [1:0]        pqOp;
  logic [1:0]        pqNext;
  logic              noteOp;
  logic              noteFire;
  logic              owed;
  logic              pop;
  logic [NOTE_W-1:0] cntQ;
  logic [2:0]        trigA;
  logic [2:0]        trigB;

  // Stage 1: the request's operation
  always_comb begin
    trigA  = pqTrigger(pqQ);
    pqOp   = pqQ;
    noteOp = 1'b0;
    case (strb.op)
      OP_SET00: pqOp = 2'b00;
      OP_SET01: pqOp = 2'b01;
      OP_STEOI: begin
        if (pqQ[0]) begin
          pqOp   = 2'b10;
          noteOp = 1'b1;
        end else begin
          pqOp   = 2'b00;
        end
      end
      OP_TRIG: {noteOp, pqOp} = trigA;
      default: pqOp = pqQ;
    endcase
  end

  // Stage 2: line trigger on the result of stage 1
  always_comb begin
    trigB = pqTrigger(pqOp);
    if (strb.fire) {noteFire, pqNext} = trigB;
    else           {noteFire, pqNext} = {1'b0, pqOp};
  end

  assign owed = noteOp | noteFire;
  assign pop  = notifValid & notifReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pqQ      <= 2'b00;
      cntQ     <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      pqQ      <= pqNext;
      rspValid <= strb.isLoad;
      rspData  <= strb.isLoad ? RD_W'(pqQ) : '0;
      if (owed && !pop && cntQ != CNT_MAX) cntQ <= cntQ + 1'b1;
      else if (!owed && pop)               cntQ <= cntQ - 1'b1;
    end
  end

  assign notifValid = (cntQ != '0);
  assign notifId    = SRC_ID;
  assign pqNow      = pqQ;

endmodule

// File: rtl/esb_src.sv
module esb_src
  import esb_pkg::*;
#(
  parameter int              OFF_W    = 12,
  parameter int              RD_W     = 8,
  parameter int              NOTE_W   = 3,
  parameter int              SRC_ID_W = 8,
  parameter logic [SRC_ID_W-1:0] SRC_ID = 8'h2A,
  parameter bit              IS_LEVEL = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqPage,
  input  logic [OFF_W-1:0]    reqOffset,
  input  logic                lvlIn,
  output logic                rspValid,
  output logic [RD_W-1:0]     rspData,
  output logic                notifValid,
  input  logic                notifReady,
  output logic [SRC_ID_W-1:0] notifId
);

  esbStrobe_t strb;
  logic [1:0] pqNow;

  esb_ctrl #(.OFF_W(OFF_W), .IS_LEVEL(IS_LEVEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPage(reqPage), .reqOffset(reqOffset), .lvlIn(lvlIn), .strb(strb)
  );

  esb_dp #(.RD_W(RD_W), .NOTE_W(NOTE_W), .SRC_ID_W(SRC_ID_W), .SRC_ID(SRC_ID)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .notifReady(notifReady),
    .rspValid(rspValid), .rspData(rspData), .notifValid(notifValid),
    .notifId(notifId), .pqNow(pqNow)
  );

endmodule

// File: rtl/esb_src_chk.sv
module esb_src_chk #(
  parameter int OFF_W    = 12,
  parameter int RD_W     = 8,
  parameter int SRC_ID_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqWrite,
  input logic                reqPage,
  input logic [OFF_W-1:0]    reqOffset,
  input logic                rspValid,
  input logic [RD_W-1:0]     rspData,
  input logic                notifValid,
  input logic                notifReady,
  input logic [SRC_ID_W-1:0] notifId,
  input logic [1:0]          pqNow
);

  // R9
  notif_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    notifValid && !notifReady |=> notifValid && $stable(notifId));

  // R4
  rsp_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite |=> rspValid);

  // R8
  no_rsp_on_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> !rspValid);

  // R4
  rsp_old_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> rspData == RD_W'($past(pqNow)));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite && !reqPage && reqOffset == OFF_W'(12'hD00) |=> pqNow == 2'b01);

  // R3
  masked_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid && pqNow == 2'b01 |=> pqNow == 2'b01);

endmodule

bind esb_src esb_src_chk #(.OFF_W(OFF_W), .RD_W(RD_W), .SRC_ID_W(SRC_ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqPage(reqPage), .reqOffset(reqOffset), .rspValid(rspValid),
  .rspData(rspData), .notifValid(notifValid), .notifReady(notifReady),
  .notifId(notifId), .pqNow(pqNow)
);

// File: tb/esb_src_tb.sv
module esb_src_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0, reqPage = 1'b0;
  logic [11:0] reqOffset = '0;
  logic        sel = 1'b0;
  logic        lvl1 = 1'b0;
  logic        rdy0 = 1'b0, rdy1 = 1'b0;

  logic       rv0, rv1, nv0, nv1;
  logic [7:0] rd0, rd1, id0, id1;

  int nTests = 0, nFail = 0;
  logic       lastRv;
  logic [7:0] lastRd;

  esb_src #(.SRC_ID(8'h2A), .IS_LEVEL(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid && !sel), .reqWrite(reqWrite),
    .reqPage(reqPage), .reqOffset(reqOffset), .lvlIn(1'b0),
    .rspValid(rv0), .rspData(rd0), .notifValid(nv0), .notifReady(rdy0), .notifId(id0)
  );

  esb_src #(.SRC_ID(8'h5C), .IS_LEVEL(1'b1)) u_dutLvl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid && sel), .reqWrite(reqWrite),
    .reqPage(reqPage), .reqOffset(reqOffset), .lvlIn(lvl1),
    .rspValid(rv1), .rspData(rd1), .notifValid(nv1), .notifReady(rdy1), .notifId(id1)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic curNv();
    return sel ? nv1 : nv0;
  endfunction

  task automatic doReq(input bit w, input bit pg, input logic [11:0] off, input bit raise);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqPage = pg; reqOffset = off;
    if (raise) lvl1 = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    lastRv = sel ? rv1 : rv0;
    lastRd = sel ? rd1 : rd0;
  endtask

  task automatic drain(output int n);
    n = 0;
    if (sel) rdy1 = 1'b1; else rdy0 = 1'b1;
    while (curNv() && n < 20) begin
      // R9 source number
      check((sel ? id1 : id0) == (sel ? 8'h5C : 8'h2A), "R9", "notifId",
            sel ? id1 : id0, sel ? 8'h5C : 8'h2A);
      n++;
      @(negedge clk);
    end
    rdy0 = 1'b0; rdy1 = 1'b0;
  endtask

  task automatic query(output logic [1:0] pq);
    doReq(1'b0, 1'b0, 12'h800, 1'b0);
    pq = lastRd[1:0];
  endtask

  task automatic fireOnce();
    if (sel) begin
      @(negedge clk); lvl1 = 1'b1;
      @(negedge clk); lvl1 = 1'b0;
    end else begin
      doReq(1'b1, 1'b1, 12'h000, 1'b0);
    end
  endtask

  task automatic setState(input logic [1:0] pq);
    int n;
    lvl1 = 1'b0;
    doReq(1'b0, 1'b0, 12'hC00, 1'b0);
    if (pq == 2'b01) doReq(1'b0, 1'b0, 12'hD00, 1'b0);
    if (pq[1]) fireOnce();
    if (pq == 2'b11) fireOnce();
    @(negedge clk);
    drain(n);
  endtask

  // op: 0 load 0x000, 1 load 0xC00, 2 load 0xD00, 3 store 0x400,
  //     4 trigger-page store, 5 load 0x800, 6 store 0xC00, 7 trigger-page load
  task automatic opDecode(input int op, output bit w, output bit pg, output logic [11:0] off);
    case (op)
      0: begin w = 0; pg = 0; off = 12'h000; end
      1: begin w = 0; pg = 0; off = 12'hC00; end
      2: begin w = 0; pg = 0; off = 12'hD00; end
      3: begin w = 1; pg = 0; off = 12'h400; end
      4: begin w = 1; pg = 1; off = 12'h0F8; end
      5: begin w = 0; pg = 0; off = 12'h800; end
      6: begin w = 1; pg = 0; off = 12'hC00; end
      default: begin w = 0; pg = 1; off = 12'h000; end
    endcase
  endtask

  function automatic logic [2:0] trig(input logic [1:0] pq);
    if (pq == 2'b00) return 3'b110;
    if (pq == 2'b01) return 3'b001;
    return 3'b011;
  endfunction

  // returns {notifs, state}
  function automatic logic [3:0] model(input logic [1:0] pq, input int op,
                                       input bit lvl, input bit edgeNow);
    logic [1:0] p;
    int n;
    logic [2:0] t;
    bit eoi;
    p = pq; n = 0;
    case (op)
      0, 1: p = 2'b00;
      2:    p = 2'b01;
      3:    if (pq[0]) begin p = 2'b10; n = 1; end else p = 2'b00;
      4:    if (!lvl) begin t = trig(pq); p = t[1:0]; n = t[2]; end
      default: p = pq;
    endcase
    eoi = (op == 0) || (op == 1) || (op == 3);
    if (lvl && (edgeNow || eoi && edgeNow)) begin
      t = trig(p); p = t[1:0]; n = n + t[2];
    end
    return {2'(n), p};
  endfunction

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int n;
    logic [1:0] pq;
    bit w, pg;
    logic [11:0] off;
    logic [3:0] ex;
    bit isLd;

    repeat (3) @(negedge clk);
    // R1 reset outputs
    check(!rv0 && !rv1, "R1", "rspValid in reset", rv0 | rv1, 0);
    check(!nv0 && !nv1, "R1", "notifValid in reset", nv0 | nv1, 0);
    rstN = 1'b1;
    @(negedge clk);
    sel = 0; query(pq); check(pq == 2'b00, "R1", "state after reset msg", pq, 0);
    sel = 1; query(pq); check(pq == 2'b00, "R1", "state after reset lvl", pq, 0);

    // Exhaustive sweep: variant x line-raise x start state x op (R2..R8, R10, R12)
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m <= s; m++) begin
        for (int p0 = 0; p0 < 4; p0++) begin
          for (int op = 0; op < 8; op++) begin
            sel = s[0];
            setState(2'(p0));
            opDecode(op, w, pg, off);
            isLd = !w;
            ex = model(2'(p0), op, s[0], m[0]);
            doReq(w, pg, off, m[0]);
            lvl1 = 1'b0;
            // R4 R5 R6 R8 load response and old state
            check(lastRv == isLd, "R4", $sformatf("rspValid op%0d", op), lastRv, isLd);
            if (isLd)
              check(lastRd == {6'd0, 2'(p0)}, "R8", $sformatf("old state op%0d", op), lastRd, p0);
            drain(n);
            // R2 R3 R7 R10 R12 notifications
            check(n == int'(ex[3:2]), s ? "R12" : "R2",
                  $sformatf("notifs s%0d m%0d p%0d op%0d", s, m, p0, op), n, ex[3:2]);
            query(pq);
            check(pq == ex[1:0], s ? "R10" : "R3",
                  $sformatf("state s%0d m%0d p%0d op%0d", s, m, p0, op), pq, ex[1:0]);
          end
        end
      end
    end

    // R11: steady high line refires after end-of-interrupt
    sel = 1;
    setState(2'b00);
    @(negedge clk); lvl1 = 1'b1;
    @(negedge clk);
    drain(n); check(n == 1, "R10", "edge notif", n, 1);
    doReq(0, 0, 12'hC00, 0);
    check(lastRd[1:0] == 2'b10, "R11", "unmask old state", lastRd, 2);
    drain(n); check(n == 1, "R11", "refire after C00", n, 1);
    query(pq); check(pq == 2'b10, "R11", "state after refire", pq, 2);
    doReq(0, 0, 12'hD00, 0);
    drain(n); check(n == 0, "R11", "mask no refire", n, 0);
    doReq(1, 0, 12'h400, 0);
    drain(n); check(n == 1, "R11", "store eoi from masked", n, 1);
    query(pq); check(pq == 2'b11, "R11", "store eoi then refire", pq, 3);
    doReq(0, 0, 12'h000, 0);
    drain(n); check(n == 1, "R11", "load eoi refire", n, 1);
    lvl1 = 1'b0;
    doReq(0, 0, 12'hC00, 0);
    drain(n); check(n == 0, "R11", "line low no refire", n, 0);
    query(pq); check(pq == 2'b00, "R11", "final state", pq, 0);

    // R9: backlog while receiver stalled
    sel = 0;
    setState(2'b00);
    for (int k = 0; k < 3; k++) begin
      doReq(1, 1, 12'h010, 0);
      doReq(0, 0, 12'hC00, 0);
    end
    repeat (4) @(negedge clk);
    check(nv0, "R9", "held while not ready", nv0, 1);
    drain(n); check(n == 3, "R9", "backlog drained", n, 3);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule